// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave

This block behaves as the slave side of a three-wire serial EEPROM. The wires are a chip select, a serial clock and a data input, and the block drives one data output. A host raises chip select and clocks in a frame: a start bit (the first 1 seen), a two-bit opcode and an address field. Some opcodes then take a data word. The block decodes the frame and acts on an internal word array. It can read one word, read on through consecutive words, write, erase, erase the whole array, fill the whole array with one word, enable programming and disable programming.

All serial inputs are oversampled by a fast system clock. Changes to the array run as a self-timed programming cycle whose length is set in system clock cycles. The cycle starts when chip select falls after a complete write-type frame. While it runs, the data output reports busy (low), and it reports ready (high) once the cycle ends. The array is written through a single synchronous port with a registered read, so it maps onto block RAM.

Top module: `eep3w_slave`

## Requirements
- R1: After reset the data output is high (ready), no programming cycle is running, and programming is disabled.
- R2: Input bits are taken only on rising serial clock edges while chip select is high. Zeros before the first 1 are skipped, and that first 1 is the start bit.
- R3: Opcode 10 reads. After the last address bit the output shows one 0 dummy bit. Each following rising edge then presents the next bit of the addressed word, MSB first.
- R4: If clocking continues after a read word, the word at the next address follows with no dummy bit. The address wraps from the top of the array to 0.
- R5: Opcode 01 with a data word writes that word. The location is erased to all ones before programming, so the stored value equals the supplied word exactly, whatever it held before.
- R6: Opcode 11 sets the addressed word to all ones.
- R7: Opcode 00 with address top bits 10 sets every word in the array to all ones.
- R8: Opcode 00 with address top bits 01, followed by a data word, writes that word into every location.
- R9: Opcode 00 with top bits 11 enables programming, and top bits 00 disable it. While programming is disabled, write-type frames change nothing and start no cycle. Once enabled, programming stays enabled across any number of operations until a disable frame or a reset.
- R10: A programming cycle starts when chip select falls after a complete write-type frame, and it lasts max(PROG_CYCLES, 2^ADDR_W) cycles. Outside a read the output is low while busy and high when ready. Start bits that arrive during the cycle are ignored.
- R11: Once a frame is fully loaded, further clocks and data are ignored until chip select falls.
- R12: If chip select falls before a frame is complete, the frame is discarded and the array is left unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial wires |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Chip select, active high |
| sclk | input | 1 | Serial clock from the host |
| di | input | 1 | Serial data into the block |
| dout | output | 1 | Serial read data, or ready (1) / busy (0) status |

## Verification
The assertions check four things on every cycle. The output stays low during a programming cycle. The array is written only inside that cycle. A cycle starts only while programming is enabled, and it never outruns its length. The frame decoder also stays idle while chip select is low or a cycle is running. Only the bench scenarios can show what actually lands in the array: exact words after writes over old data, whole-array fills and erases, the dummy bit and MSB-first order of a read, the wrap of a sequential read, and frames that must leave contents untouched (aborted, disabled, sent during busy, or carrying trailing extra bits).

// File: rtl/eep3w_pkg.sv
package eep3w_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_OPC, ST_ADDR, ST_DATA, ST_READ, ST_DONE
  } st_t;

  typedef enum logic [2:0] {
    CMD_NONE, CMD_WRITE, CMD_ERASE, CMD_FILL_ONES, CMD_FILL_WORD
  } cmd_t;

  localparam logic [1:0] OP_SPECIAL = 2'b00;
  localparam logic [1:0] OP_WRITE   = 2'b01;
  localparam logic [1:0] OP_READ    = 2'b10;
  localparam logic [1:0] OP_ERASE   = 2'b11;

  localparam logic [1:0] SUB_LOCK   = 2'b00;
  localparam logic [1:0] SUB_FILL   = 2'b01;
  localparam logic [1:0] SUB_CLEAR  = 2'b10;
  localparam logic [1:0] SUB_UNLOCK = 2'b11;
endpackage

// File: rtl/eep3w_sync.sv
module eep3w_sync (
  input  logic clk,
  input  logic rst,
  input  logic cs,
  input  logic sclk,
  input  logic di,
  output logic cs_s,
  output logic di_s,
  output logic sclk_rise,
  output logic cs_fall
);
  localparam int NSIG = 3;
  logic [NSIG-1:0] raw, st1, st2, st3;

  assign raw = {cs, sclk, di};

  genvar g;
  generate
    for (g = 0; g < NSIG; g++) begin : g_sync
      always_ff @(posedge clk) begin
        if (rst) begin
          st1[g] <= 1'b0;
          st2[g] <= 1'b0;
          st3[g] <= 1'b0;
        end else begin
          st1[g] <= raw[g];
          st2[g] <= st1[g];
          st3[g] <= st2[g];
        end
      end
    end
  endgenerate

  assign cs_s      = st2[2];
  assign di_s      = st2[0];
  assign sclk_rise = st2[1] & ~st3[1];
  assign cs_fall   = st3[2] & ~st2[2];
endmodule

// File: rtl/eep3w_decoder.sv
module eep3w_decoder
  import eep3w_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_s,
  input  logic              di_s,
  input  logic              sclk_rise,
  input  logic              cs_fall,
  input  logic              busy,
  input  logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              rd_bit,
  output logic              in_read,
  output logic              go,
  output cmd_t              kind,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [DATA_W-1:0] cmd_data,
  output logic              wen,
  output st_t               state
);
  localparam int MAXF = (ADDR_W > DATA_W) ? ADDR_W : DATA_W;
  localparam int CW   = $clog2(MAXF + 1);

  logic [CW-1:0]     cnt;
  logic [1:0]        opc;
  logic              pend;
  logic              dummy;
  logic [DATA_W-1:0] rsh;
  logic [ADDR_W-1:0] a_next;
  logic [DATA_W-1:0] d_next;

  assign a_next  = {cmd_addr[ADDR_W-2:0], di_s};
  assign d_next  = {cmd_data[DATA_W-2:0], di_s};
  assign in_read = (state == ST_READ);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      opc      <= '0;
      pend     <= 1'b0;
      go       <= 1'b0;
      wen      <= 1'b0;
      kind     <= CMD_NONE;
      cmd_addr <= '0;
      cmd_data <= '0;
      rd_addr  <= '0;
      rd_bit   <= 1'b1;
      dummy    <= 1'b0;
      rsh      <= '0;
    end else begin
      go <= 1'b0;
      if (!cs_s) begin
        if (cs_fall && state == ST_DONE && pend) go <= 1'b1;
        state <= ST_IDLE;
        pend  <= 1'b0;
      end else if (sclk_rise) begin
        case (state)
          ST_IDLE: begin
            if (di_s && !busy) begin
              state <= ST_OPC;
              cnt   <= '0;
            end
          end
          ST_OPC: begin
            opc <= {opc[0], di_s};
            if (cnt == CW'(1)) begin
              state <= ST_ADDR;
              cnt   <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_ADDR: begin
            cmd_addr <= a_next;
            if (cnt == CW'(ADDR_W - 1)) begin
              cnt   <= '0;
              state <= ST_DONE;
              case (opc)
                OP_READ: begin
                  state   <= ST_READ;
                  rd_addr <= a_next;
                  dummy   <= 1'b1;
                  rd_bit  <= 1'b0;
                end
                OP_WRITE: begin
                  state <= ST_DATA;
                  kind  <= CMD_WRITE;
                end
                OP_ERASE: begin
                  kind <= CMD_ERASE;
                  pend <= wen;
                end
                default: begin
                  case (a_next[ADDR_W-1 -: 2])
                    SUB_UNLOCK: wen <= 1'b1;
                    SUB_LOCK:   wen <= 1'b0;
                    SUB_CLEAR: begin
                      kind <= CMD_FILL_ONES;
                      pend <= wen;
                    end
                    default: begin
                      state <= ST_DATA;
                      kind  <= CMD_FILL_WORD;
                    end
                  endcase
                end
              endcase
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_DATA: begin
            cmd_data <= d_next;
            if (cnt == CW'(DATA_W - 1)) begin
              state <= ST_DONE;
              pend  <= wen;
              cnt   <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_READ: begin
            if (dummy || cnt == '0) begin
              rd_bit  <= rdata[DATA_W-1];
              rsh     <= {rdata[DATA_W-2:0], 1'b0};
              cnt     <= CW'(DATA_W - 1);
              rd_addr <= rd_addr + 1'b1;
              dummy   <= 1'b0;
            end else begin
              rd_bit <= rsh[DATA_W-1];
              rsh    <= {rsh[DATA_W-2:0], 1'b0};
              cnt    <= cnt - 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/eep3w_prog.sv
module eep3w_prog
  import eep3w_pkg::*;
#(
  parameter int ADDR_W   = 7,
  parameter int DATA_W   = 16,
  parameter int PROG_LEN = 400
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  cmd_t              kind,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  output logic              busy,
  output logic              we,
  output logic [ADDR_W-1:0] wa,
  output logic [DATA_W-1:0] wd
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int TW    = $clog2(PROG_LEN);

  logic [TW-1:0]     tmr;
  cmd_t              k_q;
  logic [ADDR_W-1:0] a_q;
  logic [DATA_W-1:0] d_q;
  logic              first, last, sweep;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      tmr  <= '0;
      k_q  <= CMD_NONE;
      a_q  <= '0;
      d_q  <= '0;
    end else if (!busy) begin
      if (go) begin
        busy <= 1'b1;
        tmr  <= '0;
        k_q  <= kind;
        a_q  <= addr;
        d_q  <= data;
      end
    end else if (tmr == TW'(PROG_LEN - 1)) begin
      busy <= 1'b0;
    end else begin
      tmr <= tmr + 1'b1;
    end
  end

  assign first = busy && (tmr == '0);
  assign last  = busy && (tmr == TW'(PROG_LEN - 1));
  assign sweep = busy && (int'(tmr) < DEPTH);

  always_comb begin
    we = 1'b0;
    wa = a_q;
    wd = '1;
    case (k_q)
      CMD_WRITE: begin
        we = first || last;
        wd = first ? '1 : d_q;
      end
      CMD_ERASE: we = first;
      CMD_FILL_ONES: begin
        we = sweep;
        wa = tmr[ADDR_W-1:0];
      end
      CMD_FILL_WORD: begin
        we = sweep;
        wa = tmr[ADDR_W-1:0];
        wd = d_q;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/eep3w_array.sv
module eep3w_array #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] wa,
  input  logic [DATA_W-1:0] wd,
  input  logic [ADDR_W-1:0] ra,
  output logic [DATA_W-1:0] rd
);
  localparam int DEPTH = 1 << ADDR_W;
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
    rd <= mem[ra];
  end
endmodule

// File: rtl/eep3w_slave.sv
module eep3w_slave
  import eep3w_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 16,
  parameter int PROG_CYCLES = 400
) (
  input  logic clk,
  input  logic rst,
  input  logic cs,
  input  logic sclk,
  input  logic di,
  output logic dout
);
  localparam int DEPTH    = 1 << ADDR_W;
  localparam int PROG_LEN = (PROG_CYCLES > DEPTH) ? PROG_CYCLES : DEPTH;

  logic              cs_s, di_s, sclk_rise, cs_fall;
  logic              busy, go, wen, in_read, rd_bit, mem_we;
  cmd_t              kind;
  st_t               dec_state;
  logic [ADDR_W-1:0] rd_addr, cmd_addr, mem_wa;
  logic [DATA_W-1:0] cmd_data, mem_wd, mem_rd;

  eep3w_sync u_sync (
    .clk(clk), .rst(rst), .cs(cs), .sclk(sclk), .di(di),
    .cs_s(cs_s), .di_s(di_s), .sclk_rise(sclk_rise), .cs_fall(cs_fall)
  );

  eep3w_decoder #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
    .clk(clk), .rst(rst), .cs_s(cs_s), .di_s(di_s), .sclk_rise(sclk_rise),
    .cs_fall(cs_fall), .busy(busy), .rdata(mem_rd), .rd_addr(rd_addr),
    .rd_bit(rd_bit), .in_read(in_read), .go(go), .kind(kind),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .wen(wen), .state(dec_state)
  );

  eep3w_prog #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PROG_LEN(PROG_LEN)) u_prog (
    .clk(clk), .rst(rst), .go(go), .kind(kind), .addr(cmd_addr),
    .data(cmd_data), .busy(busy), .we(mem_we), .wa(mem_wa), .wd(mem_wd)
  );

  eep3w_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk(clk), .we(mem_we), .wa(mem_wa), .wd(mem_wd), .ra(rd_addr), .rd(mem_rd)
  );

  always_ff @(posedge clk) begin
    if (rst) dout <= 1'b1;
    else     dout <= in_read ? rd_bit : ~busy;
  end
endmodule

// File: rtl/eep3w_chk.sv
module eep3w_chk
  import eep3w_pkg::*;
#(
  parameter int PROG_LEN = 400
) (
  input logic clk,
  input logic rst,
  input logic cs_s,
  input logic dout,
  input logic busy,
  input logic mem_we,
  input logic go,
  input logic wen,
  input st_t  st
);
  int len;

  always_ff @(posedge clk) begin
    if (rst)       len <= 0;
    else if (busy) len <= len + 1;
    else           len <= 0;
  end

  // R10
  busy_low_chk: assert property (@(posedge clk) disable iff (rst)
    $past(busy) |-> !dout);

  // R10
  write_in_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> busy);

  // R9
  start_enabled_chk: assert property (@(posedge clk) disable iff (rst)
    go |-> wen);

  // R10
  cycle_len_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> (len < PROG_LEN));

  // R10
  busy_idle_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> (st == ST_IDLE));

  // R12
  cs_abort_chk: assert property (@(posedge clk) disable iff (rst)
    !cs_s |=> (st == ST_IDLE));
endmodule

bind eep3w_slave eep3w_chk #(.PROG_LEN(PROG_LEN)) u_chk (
  .clk(clk), .rst(rst), .cs_s(cs_s), .dout(dout), .busy(busy),
  .mem_we(mem_we), .go(go), .wen(wen), .st(dec_state)
);

// File: tb/sim_eep3w_slave.sv
module sim_eep3w_slave;
  localparam int CLK_PERIOD  = 10;
  localparam int HALF        = 6;
  localparam int ADDR_W      = 7;
  localparam int DATA_W      = 16;
  localparam int PROG_CYCLES = 400;
  localparam int DEPTH       = 1 << ADDR_W;
  localparam int PROG_LEN    = (PROG_CYCLES > DEPTH) ? PROG_CYCLES : DEPTH;

  localparam logic [ADDR_W-1:0] A_UNLOCK = 7'h60;
  localparam logic [ADDR_W-1:0] A_LOCK   = 7'h00;
  localparam logic [ADDR_W-1:0] A_CLEAR  = 7'h40;
  localparam logic [ADDR_W-1:0] A_FILL   = 7'h20;

  logic clk = 1'b0, rst = 1'b1, cs = 1'b0, sclk = 1'b0, di = 1'b0;
  logic dout;
  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [15:0] rw [0:3];
  logic rdummy;

  always #(CLK_PERIOD/2) clk = ~clk;

  eep3w_slave #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PROG_CYCLES(PROG_CYCLES)) u0 (
    .clk(clk), .rst(rst), .cs(cs), .sclk(sclk), .di(di), .dout(dout)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic sbit(input logic b, output logic o);
    di = b;
    repeat (HALF) @(negedge clk);
    o = dout;
    sclk = 1'b1;
    repeat (HALF) @(negedge clk);
    sclk = 1'b0;
  endtask

  task automatic send(input int nb, input logic [31:0] v);
    logic o;
    for (int i = nb - 1; i >= 0; i--) sbit(v[i], o);
  endtask

  task automatic cs_on();
    @(negedge clk);
    sclk = 1'b0;
    cs = 1'b1;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic cs_off();
    repeat (HALF) @(negedge clk);
    cs = 1'b0;
    repeat (2 * HALF) @(negedge clk);
  endtask

  task automatic frame(input logic [1:0] op, input logic [ADDR_W-1:0] a,
                       input bit has_data, input logic [15:0] d);
    cs_on();
    send(1, 1);
    send(2, {30'd0, op});
    send(ADDR_W, {25'd0, a});
    if (has_data) send(DATA_W, {16'd0, d});
  endtask

  // drop cs, then poll ready with cs high; n counts cycles from the fall
  task automatic settle(output int n);
    repeat (HALF) @(negedge clk);
    cs = 1'b0;
    n = 0;
    repeat (8) begin @(negedge clk); n++; end
    cs = 1'b1;
    while (dout !== 1'b1 && n < 5000) begin @(negedge clk); n++; end
    cs = 1'b0;
    repeat (2 * HALF) @(negedge clk);
  endtask

  task automatic prog(input logic [1:0] op, input logic [ADDR_W-1:0] a,
                      input bit has_data, input logic [15:0] d, output int n);
    frame(op, a, has_data, d);
    settle(n);
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, input int nw, input int lead);
    logic o;
    cs_on();
    for (int i = 0; i < lead; i++) sbit(1'b0, o);
    send(1, 1);
    send(2, 2);
    send(ADDR_W, {25'd0, a});
    sbit(1'b0, o);
    rdummy = o;
    for (int w = 0; w < nw; w++)
      for (int b = 15; b >= 0; b--) begin
        sbit(1'b0, o);
        rw[w][b] = o;
      end
    cs_off();
  endtask

  task automatic t_reset();
    int n;
    chk(dout === 1'b1, "R1 ready after reset", {31'd0, dout}, 1);
    prog(2'b01, 7'd9, 1, 16'h0000, n);
    chk(n < 20, "R1 disabled after reset, no cycle", n, 8);
  endtask

  task automatic t_clear();
    int n;
    prog(2'b00, A_UNLOCK, 0, 0, n);
    prog(2'b00, A_CLEAR, 0, 0, n);
    chk(n >= PROG_LEN && n <= PROG_LEN + 16, "R10 cycle length", n, PROG_LEN);
    rd(7'd5, 2, 0);
    chk(rw[0] === 16'hFFFF && rw[1] === 16'hFFFF, "R7 clear all", {rw[0], rw[1]}, 32'hFFFFFFFF);
  endtask

  task automatic t_write_read();
    int n;
    prog(2'b01, 7'd3, 1, 16'h1234, n);
    rd(7'd3, 1, 3);
    chk(rdummy === 1'b0, "R3 dummy zero", {31'd0, rdummy}, 0);
    chk(rw[0] === 16'h1234, "R3 read MSB first", rw[0], 16'h1234);
    chk(rw[0] === 16'h1234, "R2 leading zeros skipped", rw[0], 16'h1234);
    prog(2'b01, 7'd4, 1, 16'hA5C3, n);
    prog(2'b01, 7'd4, 1, 16'h5A3C, n);
    rd(7'd4, 1, 0);
    chk(rw[0] === 16'h5A3C, "R5 overwrite exact (auto-erase)", rw[0], 16'h5A3C);
  endtask

  task automatic t_seq();
    int n;
    prog(2'b01, 7'd127, 1, 16'hBEEF, n);
    prog(2'b01, 7'd0, 1, 16'hCAFE, n);
    rd(7'd126, 3, 0);
    chk(rw[0] === 16'hFFFF, "R4 first word", rw[0], 16'hFFFF);
    chk(rw[1] === 16'hBEEF, "R4 next word", rw[1], 16'hBEEF);
    chk(rw[2] === 16'hCAFE, "R4 wrap to 0", rw[2], 16'hCAFE);
  endtask

  task automatic t_erase();
    int n;
    prog(2'b11, 7'd3, 0, 0, n);
    rd(7'd3, 1, 0);
    chk(rw[0] === 16'hFFFF, "R6 erase word", rw[0], 16'hFFFF);
  endtask

  task automatic t_fill();
    int n;
    prog(2'b00, A_FILL, 1, 16'h5A5A, n);
    rd(7'd0, 1, 0);
    chk(rw[0] === 16'h5A5A, "R8 fill word at 0", rw[0], 16'h5A5A);
    rd(7'd64, 1, 0);
    chk(rw[0] === 16'h5A5A, "R8 fill word at 64", rw[0], 16'h5A5A);
    rd(7'd127, 1, 0);
    chk(rw[0] === 16'h5A5A, "R8 fill word at 127", rw[0], 16'h5A5A);
  endtask

  task automatic t_lock();
    int n;
    prog(2'b00, A_LOCK, 0, 0, n);
    prog(2'b01, 7'd10, 1, 16'h0000, n);
    chk(n < 20, "R9 locked write starts no cycle", n, 8);
    rd(7'd10, 1, 0);
    chk(rw[0] === 16'h5A5A, "R9 locked write ignored", rw[0], 16'h5A5A);
    prog(2'b00, A_UNLOCK, 0, 0, n);
    prog(2'b01, 7'd10, 1, 16'h1111, n);
    prog(2'b01, 7'd11, 1, 16'h2222, n);
    rd(7'd10, 2, 0);
    chk(rw[0] === 16'h1111 && rw[1] === 16'h2222, "R9 enable persists",
        {rw[0], rw[1]}, 32'h11112222);
  endtask

  task automatic t_abort();
    cs_on();
    send(1, 1);
    send(2, 1);
    send(ADDR_W, 12);
    send(5, 5'b00000);
    cs_off();
    rd(7'd12, 1, 0);
    chk(rw[0] === 16'h5A5A, "R12 aborted write", rw[0], 16'h5A5A);
  endtask

  task automatic t_extra();
    int n;
    frame(2'b01, 7'd13, 1, 16'h00FF);
    send(8, 8'h00);
    settle(n);
    rd(7'd13, 1, 0);
    chk(rw[0] === 16'h00FF, "R11 trailing bits ignored", rw[0], 16'h00FF);
  endtask

  task automatic t_busy();
    int n;
    logic o;
    frame(2'b01, 7'd14, 1, 16'h0F0F);
    repeat (HALF) @(negedge clk);
    cs = 1'b0;
    repeat (6) @(negedge clk);
    cs = 1'b1;
    repeat (4) @(negedge clk);
    sbit(1'b1, o);
    chk(o === 1'b0, "R10 busy shows low", {31'd0, o}, 0);
    send(2, 1);
    send(ADDR_W, 15);
    send(DATA_W, 0);
    n = 0;
    while (dout !== 1'b1 && n < 5000) begin @(negedge clk); n++; end
    chk(dout === 1'b1, "R10 ready after cycle", {31'd0, dout}, 1);
    cs_off();
    rd(7'd14, 2, 0);
    chk(rw[0] === 16'h0F0F, "R10 write before busy", rw[0], 16'h0F0F);
    chk(rw[1] === 16'h5A5A, "R10 frame during busy ignored", rw[1], 16'h5A5A);
  endtask

  task automatic t_reset_lock();
    int n;
    @(negedge clk) rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk(dout === 1'b1, "R1 ready after second reset", {31'd0, dout}, 1);
    prog(2'b01, 7'd20, 1, 16'h0000, n);
    rd(7'd20, 1, 0);
    chk(rw[0] === 16'h5A5A, "R9 reset clears enable", rw[0], 16'h5A5A);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    t_clear();
    t_write_read();
    t_seq();
    t_erase();
    t_fill();
    t_lock();
    t_abort();
    t_extra();
    t_busy();
    t_reset_lock();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule